// File: doc/BRIEF.md
# Byte-wise Block Expansion Unit

This unit widens an 80-bit block into a 120-bit or 128-bit block by weaving redundancy bytes between the original data bytes. The ten input bytes are grouped into five adjacent pairs. Each pair receives one extra byte, either its XOR or its modulo-256 sum, placed on a side that depends on the selected method. Depending on the method, one more byte then summarises the five inserted bytes. Byte and bit indices count from the right, starting at zero. Pair p is made of input bytes 2p+1 (the left byte) and 2p (the right byte).

There are three methods. The first is a plain XOR widening. The second is a data widening that adds a checksum byte on the right; it can reverse the byte order first. The third is a key widening; a front end can first fold a repeated 16-bit value into the key material. A per-transfer request selects the method and its options. One result is produced per accepted request, one cycle after acceptance. A valid/ready pair on each side lets the producer and the consumer apply back-pressure.

Top module: `byte_expander`

## Requirements
- R1: With mode 0 (XOR widening) and pad 0, output byte 3p+2 equals input byte 2p+1, byte 3p+1 equals input byte 2p, and byte 3p equals their XOR, for p = 0..4. Output byte 15 is zero. The rev and mix options have no effect in this mode.
- R2: With mode 0 and pad 1, the 120-bit result of R1 occupies output bytes 15..1 and byte 0 is zero. In every other mode, pad has no effect.
- R3: With mode 1 (data widening), output bytes 15..1 hold the R1 layout and byte 0 holds the modulo-256 sum of the five XOR bytes.
- R4: With mode 1 and rev 1, input byte i is replaced by input byte 9-i before the widening. In every other mode, rev has no effect.
- R5: With mode 2 (key widening), output byte 3p+2 is the modulo-256 sum of input bytes 2p+1 and 2p, byte 3p+1 is input byte 2p+1, and byte 3p is input byte 2p. Output byte 15 is the XOR of the five sum bytes.
- R6: With mode 2 and mix 1, each odd input byte is XORed with seed[15:8] and each even input byte with seed[7:0] before the key widening. In every other mode, mix and seed have no effect.
- R7: Mode 3 produces an all-zero output block.
- R8: While reset is high and after it falls, out_valid is low and in_ready is high until a request is accepted.
- R9: A request is accepted on a clock edge where in_valid and in_ready are both high. On the next cycle, out_valid is high and out_data carries that request's result.
- R10: While out_valid is high and out_ready is low, out_valid stays high, out_data does not change and in_ready is low.
- R11: While out_ready is high, in_ready is high, so one request per cycle is accepted and results leave in request order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Unit can take a request this cycle |
| in_data | input | 80 | Block to widen, byte 0 rightmost |
| in_mode | input | 2 | 0 XOR widening, 1 data widening, 2 key widening, 3 zero |
| in_rev | input | 1 | Reverse byte order (mode 1 only) |
| in_pad | input | 1 | Place the 120-bit result on the left with a zero byte on the right (mode 0 only) |
| in_mix | input | 1 | Fold the seed into the key material (mode 2 only) |
| in_seed | input | 16 | Value repeated five times for the fold |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_data | output | 128 | Widened block |

## Verification
The checker assumes a well-behaved consumer and producer. Reset is held for several cycles at start, in_mode is never unknown while in_valid is high, and request fields stay steady while a request waits for in_ready. The bench drives each request's fields together with in_valid and keeps them until the acceptance edge. It changes inputs only shortly after a rising edge and varies out_ready in fixed phases: always ready, stalled, and pseudo-random. The assertions tie result byte relations to the mode and pad that the checker latched at acceptance.

// File: rtl/bxp_pkg.sv
package bxp_pkg;

    localparam int NPAIR  = 5;
    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        MD_XOR = 2'd0,
        MD_SUM = 2'd1,
        MD_KEY = 2'd2,
        MD_RSV = 2'd3
    } mode_e;

    function automatic mode_e to_mode(input logic [1:0] raw);
        return mode_e'(raw);
    endfunction

endpackage

// File: rtl/bxp_front.sv
module bxp_front #(
    parameter int NP = bxp_pkg::NPAIR,
    parameter int BW = bxp_pkg::BYTE_W
) (
    input  logic [2*NP*BW-1:0] raw_data,
    input  bxp_pkg::mode_e     mode,
    input  logic               rev,
    input  logic               mix,
    input  logic [2*BW-1:0]    seed,
    output logic [2*NP*BW-1:0] prep_data
);
    localparam int NB = 2 * NP;

    logic [NB*BW-1:0] flipped;
    logic [NB*BW-1:0] folded;

    for (genvar i = 0; i < NB; i++) begin : g_byte
        assign flipped[i*BW +: BW] = raw_data[(NB-1-i)*BW +: BW];
        assign folded[i*BW +: BW]  = raw_data[i*BW +: BW] ^ seed[(i%2)*BW +: BW];
    end

    always_comb begin
        prep_data = raw_data;
        if (mode == bxp_pkg::MD_SUM && rev) prep_data = flipped;
        if (mode == bxp_pkg::MD_KEY && mix) prep_data = folded;
    end
endmodule

// File: rtl/bxp_expand.sv
module bxp_expand #(
    parameter int NP = bxp_pkg::NPAIR,
    parameter int BW = bxp_pkg::BYTE_W
) (
    input  logic [2*NP*BW-1:0]     src,
    input  bxp_pkg::mode_e         mode,
    input  logic                   pad,
    output logic [(3*NP+1)*BW-1:0] dst
);
    localparam int MID_W = 3 * NP * BW;

    logic [BW-1:0]    xb [NP];
    logic [BW-1:0]    sb [NP];
    logic [MID_W-1:0] xor_body;
    logic [MID_W-1:0] key_body;
    logic [BW-1:0]    chk_sum;
    logic [BW-1:0]    key_top;

    for (genvar p = 0; p < NP; p++) begin : g_pair
        logic [BW-1:0] hi, lo;
        assign hi    = src[(2*p+1)*BW +: BW];
        assign lo    = src[(2*p)*BW +: BW];
        assign xb[p] = hi ^ lo;
        assign sb[p] = hi + lo;

        assign xor_body[(3*p+2)*BW +: BW] = hi;
        assign xor_body[(3*p+1)*BW +: BW] = lo;
        assign xor_body[(3*p)*BW   +: BW] = xb[p];

        assign key_body[(3*p+2)*BW +: BW] = sb[p];
        assign key_body[(3*p+1)*BW +: BW] = hi;
        assign key_body[(3*p)*BW   +: BW] = lo;
    end

    always_comb begin
        chk_sum = '0;
        key_top = '0;
        for (int p = 0; p < NP; p++) begin
            chk_sum = chk_sum + xb[p];
            key_top = key_top ^ sb[p];
        end
    end

    always_comb begin
        unique case (mode)
            bxp_pkg::MD_XOR: dst = pad ? {xor_body, {BW{1'b0}}} : {{BW{1'b0}}, xor_body};
            bxp_pkg::MD_SUM: dst = {xor_body, chk_sum};
            bxp_pkg::MD_KEY: dst = {key_top, key_body};
            default:         dst = '0;
        endcase
    end
endmodule

// File: rtl/byte_expander.sv
module byte_expander #(
    parameter int NP    = bxp_pkg::NPAIR,
    parameter int BW    = bxp_pkg::BYTE_W,
    parameter int IN_W  = 2 * NP * BW,
    parameter int OUT_W = (3 * NP + 1) * BW,
    parameter int SD_W  = 2 * BW
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [IN_W-1:0]  in_data,
    input  logic [1:0]       in_mode,
    input  logic             in_rev,
    input  logic             in_pad,
    input  logic             in_mix,
    input  logic [SD_W-1:0]  in_seed,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [OUT_W-1:0] out_data
);
    import bxp_pkg::*;

    mode_e            mode;
    logic [IN_W-1:0]  prep;
    logic [OUT_W-1:0] wide;
    logic             take;

    assign mode     = to_mode(in_mode);
    assign in_ready = !out_valid || out_ready;
    assign take     = in_valid && in_ready;

    bxp_front #(.NP(NP), .BW(BW)) u_front (
        .raw_data (in_data),
        .mode     (mode),
        .rev      (in_rev),
        .mix      (in_mix),
        .seed     (in_seed),
        .prep_data(prep)
    );

    bxp_expand #(.NP(NP), .BW(BW)) u_expand (
        .src (prep),
        .mode(mode),
        .pad (in_pad),
        .dst (wide)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else if (take) begin
            out_valid <= 1'b1;
            out_data  <= wide;
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end
endmodule

// File: rtl/bxp_checker.sv
module bxp_checker #(
    parameter int BW    = bxp_pkg::BYTE_W,
    parameter int OUT_W = (3 * bxp_pkg::NPAIR + 1) * BW
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic             in_ready,
    input logic [1:0]       in_mode,
    input logic             in_pad,
    input logic             out_valid,
    input logic             out_ready,
    input logic [OUT_W-1:0] out_data
);
    logic [1:0] held_mode;
    logic       held_pad;

    always_ff @(posedge clk) begin
        if (rst) begin
            held_mode <= 2'd0;
            held_pad  <= 1'b0;
        end else if (in_valid && in_ready) begin
            held_mode <= in_mode;
            held_pad  <= in_pad;
        end
    end

    // R8: leaving reset with nothing pending
    a_r8_idle_after_reset: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!out_valid && in_ready));

    // R9: accepted request shows up next cycle
    a_r9_accept_latency: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> out_valid);

    // R10: stalled result is frozen
    a_r10_hold_stable: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    // R10: no intake while stalled
    a_r10_block_intake: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |-> !in_ready);

    // R11: consumer ready keeps intake open
    a_r11_flow: assert property (@(posedge clk) disable iff (rst)
        out_ready |-> in_ready);

    // R1: unpadded XOR widening leaves the top byte clear and the pair-0 check byte consistent
    a_r1_xor_layout: assert property (@(posedge clk) disable iff (rst)
        (out_valid && held_mode == 2'd0 && !held_pad) |->
        (out_data[OUT_W-1 -: BW] == '0 &&
         out_data[0 +: BW] == (out_data[BW +: BW] ^ out_data[2*BW +: BW])));

    // R2: padded XOR widening ends in a zero byte
    a_r2_pad_zero: assert property (@(posedge clk) disable iff (rst)
        (out_valid && held_mode == 2'd0 && held_pad) |-> (out_data[0 +: BW] == '0));

    // R5: key widening pair-0 sum byte
    a_r5_key_pair0: assert property (@(posedge clk) disable iff (rst)
        (out_valid && held_mode == 2'd2) |->
        (out_data[2*BW +: BW] == BW'(out_data[BW +: BW] + out_data[0 +: BW])));

    // R7: reserved mode yields zero
    a_r7_zero_block: assert property (@(posedge clk) disable iff (rst)
        (out_valid && held_mode == 2'd3) |-> (out_data == '0));
endmodule

bind byte_expander bxp_checker #(.BW(BW), .OUT_W(OUT_W)) u_bxp_checker (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .in_mode  (in_mode),
    .in_pad   (in_pad),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .out_data (out_data)
);

// File: tb/tb_byte_expander.sv
module tb_byte_expander;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [79:0]  in_data = '0;
    logic [1:0]   in_mode = 2'd0;
    logic         in_rev = 1'b0;
    logic         in_pad = 1'b0;
    logic         in_mix = 1'b0;
    logic [15:0]  in_seed = '0;
    logic         out_valid;
    logic         out_ready = 1'b1;
    logic [127:0] out_data;

    int n_chk = 0;
    int n_fail = 0;
    int rmode = 0;
    bit done = 0;
    logic [31:0] rng = 32'h1234_5678;
    logic [31:0] rrng = 32'h0bad_cafe;

    logic [127:0] exp_q[$];
    string        tag_q[$];

    always #10 clk = ~clk;

    byte_expander dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .in_mode(in_mode), .in_rev(in_rev), .in_pad(in_pad),
        .in_mix(in_mix), .in_seed(in_seed), .out_valid(out_valid),
        .out_ready(out_ready), .out_data(out_data)
    );

    function automatic logic [31:0] step(input logic [31:0] s);
        logic [31:0] t = s;
        t = t ^ (t << 13);
        t = t ^ (t >> 17);
        t = t ^ (t << 5);
        return t;
    endfunction

    function automatic logic [127:0] model(input logic [79:0] d, input logic [1:0] m,
                                           input logic rv, input logic pd, input logic mx,
                                           input logic [15:0] sd);
        logic [7:0] b [10];
        logic [7:0] t [10];
        logic [7:0] o [16];
        logic [7:0] acc;
        logic [127:0] r;
        for (int i = 0; i < 10; i++) b[i] = d[8*i +: 8];
        for (int i = 0; i < 10; i++) t[i] = b[i];
        if (m == 2'd1 && rv) for (int i = 0; i < 10; i++) b[i] = t[9-i];
        if (m == 2'd2 && mx) for (int i = 0; i < 10; i++) b[i] = b[i] ^ (i[0] ? sd[15:8] : sd[7:0]);
        for (int i = 0; i < 16; i++) o[i] = 8'h00;
        if (m == 2'd0 || m == 2'd1) begin
            // XOR widening into bytes 14..0, byte 15 free
            for (int p = 0; p < 5; p++) begin
                o[3*p+2] = b[2*p+1];
                o[3*p+1] = b[2*p];
                o[3*p]   = b[2*p+1] ^ b[2*p];
            end
            if (m == 2'd1 || pd) begin
                for (int i = 15; i > 0; i--) o[i] = o[i-1];
                o[0] = 8'h00;
                if (m == 2'd1) begin
                    acc = 8'h00;
                    for (int p = 0; p < 5; p++) acc = acc + (b[2*p+1] ^ b[2*p]);
                    o[0] = acc;
                end
            end
        end else if (m == 2'd2) begin
            acc = 8'h00;
            for (int p = 0; p < 5; p++) begin
                o[3*p]   = b[2*p];
                o[3*p+1] = b[2*p+1];
                o[3*p+2] = b[2*p+1] + b[2*p];
                acc = acc ^ o[3*p+2];
            end
            o[15] = acc;
        end
        for (int i = 0; i < 16; i++) r[8*i +: 8] = o[i];
        return r;
    endfunction

    task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    task automatic send(input logic [79:0] d, input logic [1:0] m, input logic rv,
                        input logic pd, input logic mx, input logic [15:0] sd,
                        input string req, input bit must_flow);
        bit acc;
        bit first = 1;
        in_data = d; in_mode = m; in_rev = rv; in_pad = pd; in_mix = mx; in_seed = sd;
        in_valid = 1'b1;
        do begin
            @(negedge clk);
            acc = in_ready;
            // R11: with the consumer always ready, intake never blocks
            if (must_flow && first) check(acc, "R11", {127'd0, acc}, 128'd1);
            first = 0;
            @(posedge clk);
            #2;
        end while (!acc);
        in_valid = 1'b0;
        exp_q.push_back(model(d, m, rv, pd, mx, sd));
        tag_q.push_back(req);
    endtask

    task automatic send_rand(input logic [1:0] m, input logic rv, input logic pd,
                             input logic mx, input string req, input bit must_flow);
        logic [79:0] d;
        rng = step(rng); d[31:0] = rng;
        rng = step(rng); d[63:32] = rng;
        rng = step(rng); d[79:64] = rng[15:0];
        send(d, m, rv, pd, mx, rng[31:16], req, must_flow);
    endtask

    // consumer side
    initial begin
        forever begin
            @(posedge clk);
            #2;
            rrng = step(rrng);
            out_ready = (rmode == 0) ? 1'b1 : (rmode == 1) ? 1'b0 : rrng[3];
        end
    end

    // monitor / scoreboard
    initial begin
        logic         was_held = 0;
        logic [127:0] held_d = '0;
        forever begin
            @(negedge clk);
            if (!rst) begin
                if (was_held)
                    check(out_valid && out_data == held_d, "R10", out_data, held_d);
                if (out_valid && !out_ready)
                    check(!in_ready, "R10", {127'd0, in_ready}, 128'd0);
                was_held = out_valid && !out_ready;
                held_d = out_data;
                if (out_valid && out_ready) begin
                    if (exp_q.size() == 0) begin
                        check(0, "R9", out_data, 128'd0);
                    end else begin
                        logic [127:0] e;
                        string t;
                        e = exp_q.pop_front();
                        t = tag_q.pop_front();
                        check(out_data == e, t, out_data, e);
                    end
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        // R8: idle during reset
        check(!out_valid && in_ready, "R8", {126'd0, out_valid, in_ready}, 128'd1);
        @(posedge clk); #2;
        rst = 1'b0;
        @(negedge clk);
        check(!out_valid && in_ready, "R8", {126'd0, out_valid, in_ready}, 128'd1);

        rmode = 0;
        @(posedge clk); #2;
        // R1: XOR widening, flags that must not matter set too
        send(80'h0102_0304_0506_0708_090A, 2'd0, 1'b0, 1'b0, 1'b0, 16'h0, "R1", 1);
        send(80'hFFFF_FFFF_FFFF_FFFF_FFFF, 2'd0, 1'b1, 1'b0, 1'b1, 16'hA5A5, "R1", 1);
        // R2: padded XOR widening; pad ignored elsewhere
        send(80'h1122_3344_5566_7788_99AA, 2'd0, 1'b0, 1'b1, 1'b0, 16'h0, "R2", 1);
        send(80'h1122_3344_5566_7788_99AA, 2'd1, 1'b0, 1'b1, 1'b0, 16'h0, "R2", 1);
        send(80'h1122_3344_5566_7788_99AA, 2'd2, 1'b0, 1'b1, 1'b0, 16'h0, "R2", 1);
        // R3: checksum wraps modulo 256
        send(80'hFF00_FF00_FF00_FF00_FF00, 2'd1, 1'b0, 1'b0, 1'b0, 16'h0, "R3", 1);
        send(80'h0000_0000_0000_0000_0000, 2'd1, 1'b0, 1'b0, 1'b0, 16'h0, "R3", 1);
        // R4: byte reversal only in data mode
        send(80'h0102_0304_0506_0708_090A, 2'd1, 1'b1, 1'b0, 1'b0, 16'h0, "R4", 1);
        send(80'h0102_0304_0506_0708_090A, 2'd2, 1'b1, 1'b0, 1'b0, 16'h0, "R4", 1);
        // R5: key widening with carries
        send(80'h80FF_80FF_80FF_80FF_80FF, 2'd2, 1'b0, 1'b0, 1'b0, 16'h0, "R5", 1);
        send(80'h0102_0304_0506_0708_090A, 2'd2, 1'b0, 1'b0, 1'b0, 16'hFFFF, "R5", 1);
        // R6: seed fold in key mode only
        send(80'h0102_0304_0506_0708_090A, 2'd2, 1'b0, 1'b0, 1'b1, 16'hF00F, "R6", 1);
        send(80'h0102_0304_0506_0708_090A, 2'd1, 1'b0, 1'b0, 1'b1, 16'hF00F, "R6", 1);
        // R7: reserved mode
        send(80'hDEAD_BEEF_0123_4567_89AB, 2'd3, 1'b1, 1'b1, 1'b1, 16'h1234, "R7", 1);
        // R11: back-to-back random mix
        for (int k = 0; k < 40; k++)
            send_rand(rng[1:0], rng[5], rng[9], rng[13], "R11", 1);

        // R9 / R10: single result held by a stalled consumer
        repeat (3) @(posedge clk);
        rmode = 1;
        @(posedge clk); #2;
        send(80'h5A5A_0000_1234_FFFF_0F0F, 2'd2, 1'b0, 1'b0, 1'b1, 16'h3C3C, "R9", 0);
        @(negedge clk);
        check(out_valid && out_data == model(80'h5A5A_0000_1234_FFFF_0F0F, 2'd2, 1'b0, 1'b0, 1'b1, 16'h3C3C),
              "R9", out_data, model(80'h5A5A_0000_1234_FFFF_0F0F, 2'd2, 1'b0, 1'b0, 1'b1, 16'h3C3C));
        repeat (4) @(posedge clk);
        rmode = 0;
        repeat (3) @(posedge clk);

        // R10: random back-pressure
        rmode = 2;
        @(posedge clk); #2;
        for (int k = 0; k < 60; k++)
            send_rand(rng[1:0], rng[7], rng[11], rng[17], "R10", 0);
        rmode = 0;
        for (int k = 0; k < 200 && exp_q.size() != 0; k++) @(posedge clk);
        @(negedge clk);
        check(exp_q.size() == 0, "R11", 128'(exp_q.size()), 128'd0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule